// File: doc/BRIEF.md
# Serpentine Tiled Framebuffer Offset Generator

This block maps a pixel coordinate of a 32-bit-per-pixel image to the byte offset of that pixel inside a three-level tiled memory layout. The smallest unit is a 64-byte block of 4x4 pixels stored line by line. Sixteen of these, arranged 4x4 line by line, form a 1 KB subtile of 16x16 pixels. Four subtiles form a 4 KB tile of 32x32 pixels. Tiles are packed row after row, and the direction of each tile row alternates. The order of the four subtiles inside a tile also changes with that row parity.

A request gives the image width in pixels, an (x, y) coordinate and a valid strobe. Exactly two clock cycles later the block returns the byte offset, relative to the start of the image, with its own valid strobe. A new request can be accepted on every cycle. Line 0 belongs to tile row 0. Inside a tile, the "bottom" half is the one holding the smaller line numbers.

Top module: `tfb_addr_gen`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first edge after it, out_valid is 0 and out_ofs is 0.
- R2: out_valid is high exactly two rising edges after each edge that samples in_valid high, and low otherwise. Back-to-back requests produce back-to-back results.
- R3: The number of tiles in a tile row is (in_width + 31) >> 5. It must lie between 1 and 127, so widths that are not multiples of 32 round up to a whole tile.
- R4: out_ofs bits [5:0] equal ((y mod 4) * 4 + (x mod 4)) * 4, the pixel position inside its 64-byte block.
- R5: out_ofs bits [9:6] equal ((y >> 2) mod 4) * 4 + ((x >> 2) mod 4), the block position inside its subtile.
- R6: In an even tile row ((y >> 5) even), out_ofs bits [11:10] hold the subtile slot: bottom-left 0, top-left 1, top-right 2, bottom-right 3. Here "right" is x bit 4 = 1 and "top" is y bit 4 = 1.
- R7: In an odd tile row, the subtile slot is top-right 0, bottom-right 1, bottom-left 2, top-left 3.
- R8: In an odd tile row, the tile lies at column position tiles_per_row - 1 - (x >> 5), so that row is stored right to left. The coordinate must satisfy x < in_width.
- R9: out_ofs bits above 11 equal (y >> 5) * tiles_per_row + column position. In an even row the column position is x >> 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_width | input | X_W (12) | Image width in pixels |
| in_x | input | X_W (12) | Pixel column |
| in_y | input | Y_W (12) | Pixel line |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_ofs | output | Y_W-5+TPR_W+12 (26) | Byte offset of the pixel |

## Verification
On every cycle, assertions check the two-stage valid pipeline, the legal range of the tile count and of the column, and that the low twelve offset bits are carried unchanged from the first stage. They also check that the tile index never reaches the end of the addressed tile row. Only the bench's scenarios can show the actual layout. The serpentine column mirroring, the parity-dependent subtile order and the in-block pixel placement are compared field by field against an independently written offset function. This runs over random widths that are not multiples of 32, and over directed edge coordinates such as the last column of an odd row and the widest legal image.

// File: rtl/tfb_pkg.sv
package tfb_pkg;
   localparam int TILE_LG     = 5;   // 32 pixels per tile edge
   localparam int TILE_BYTES  = 12;  // 4 KB per tile
   localparam int INTRA_BITS  = 10;  // byte offset inside a subtile

   typedef enum logic [1:0] {
      SLOT_0 = 2'd0,
      SLOT_1 = 2'd1,
      SLOT_2 = 2'd2,
      SLOT_3 = 2'd3
   } slot_t;
endpackage

// File: rtl/tfb_quad_slot.sv
module tfb_quad_slot
   import tfb_pkg::*;
(
   input  logic  odd_row,
   input  logic  right_half,
   input  logic  top_half,
   output slot_t slot
);
   // Even rows walk BL, TL, TR, BR; odd rows start two places later
   // in the same cycle of quadrants, so only the high slot bit flips.
   logic [1:0] even_slot;

   always_comb begin
      even_slot = {right_half, right_half ^ top_half};
      slot      = slot_t'({even_slot[1] ^ odd_row, even_slot[0]});
   end
endmodule

// File: rtl/tfb_tile_locate.sv
module tfb_tile_locate
   import tfb_pkg::*;
#(
   parameter int X_W   = 12,
   parameter int Y_W   = 12,
   parameter int TPR_W = 7
) (
   input  logic [X_W-1:0]         width,
   input  logic [X_W-1:0]         x,
   input  logic [Y_W-1:0]         y,
   output logic [X_W-TILE_LG:0]   tpr_full,
   output logic [TPR_W-1:0]       tpr,
   output logic [Y_W-TILE_LG-1:0] tile_row,
   output logic [TPR_W-1:0]       col_pos,
   output logic [1:0]             slot,
   output logic [INTRA_BITS-1:0]  intra
);
   localparam int ROUND_W = X_W + 1;

   logic [ROUND_W-1:0] rounded;
   logic [TPR_W-1:0]   tile_col;
   logic               odd_row;
   slot_t              slot_q;

   always_comb begin
      rounded  = {1'b0, width} + ROUND_W'(31);
      tpr_full = rounded[ROUND_W-1:TILE_LG];
      tpr      = TPR_W'(tpr_full);
      tile_row = y[Y_W-1:TILE_LG];
      tile_col = TPR_W'(x[X_W-1:TILE_LG]);
      odd_row  = y[TILE_LG];
      col_pos  = odd_row ? (tpr - TPR_W'(1) - tile_col) : tile_col;
      // Block row, block column, pixel row, pixel column, 4 bytes each.
      intra    = {y[3:2], x[3:2], y[1:0], x[1:0], 2'b00};
   end

   tfb_quad_slot i_slot (
      .odd_row    (odd_row),
      .right_half (x[4]),
      .top_half   (y[4]),
      .slot       (slot_q)
   );

   assign slot = slot_q;
endmodule

// File: rtl/tfb_tile_mac.sv
module tfb_tile_mac #(
   parameter int ROW_W    = 7,
   parameter int TPR_W    = 7,
   parameter bit USE_MULT = 1'b1
) (
   input  logic [ROW_W-1:0]       row,
   input  logic [TPR_W-1:0]       tpr,
   input  logic [TPR_W-1:0]       pos,
   output logic [ROW_W+TPR_W-1:0] idx
);
   localparam int IDX_W = ROW_W + TPR_W;

   generate
      if (USE_MULT) begin : g_mult
         always_comb idx = IDX_W'(row) * IDX_W'(tpr) + IDX_W'(pos);
      end else begin : g_shift_add
         logic [IDX_W-1:0] acc [0:TPR_W];
         assign acc[0] = IDX_W'(pos);
         for (genvar i = 0; i < TPR_W; i++) begin : g_bit
            assign acc[i+1] = acc[i] + (tpr[i] ? (IDX_W'(row) << i) : '0);
         end
         assign idx = acc[TPR_W];
      end
   endgenerate
endmodule

// File: rtl/tfb_addr_gen.sv
module tfb_addr_gen
   import tfb_pkg::*;
#(
   parameter int X_W      = 12,
   parameter int Y_W      = 12,
   parameter int TPR_W    = 7,
   parameter bit USE_MULT = 1'b1,
   localparam int ROW_W   = Y_W - TILE_LG,
   localparam int IDX_W   = ROW_W + TPR_W,
   localparam int OFS_W   = IDX_W + TILE_BYTES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [X_W-1:0]   in_width,
   input  logic [X_W-1:0]   in_x,
   input  logic [Y_W-1:0]   in_y,
   output logic             out_valid,
   output logic [OFS_W-1:0] out_ofs
);
   localparam int TPR_MAX = (1 << TPR_W) - 1;

   generate
      if (X_W < TILE_LG + 1) begin : g_bad_xw
         $error("X_W must cover at least two tiles");
      end
      if (Y_W < TILE_LG + 1) begin : g_bad_yw
         $error("Y_W must cover at least two tile rows");
      end
      if (X_W > TPR_W + TILE_LG) begin : g_bad_tpr
         $error("tile count field too narrow for X_W");
      end
   endgenerate

   // Stage 0: combinational decode of the request
   logic [X_W-TILE_LG:0]  tpr_full;
   logic [TPR_W-1:0]      c_tpr, c_pos;
   logic [ROW_W-1:0]      c_row;
   logic [1:0]            c_slot;
   logic [INTRA_BITS-1:0] c_intra;

   tfb_tile_locate #(.X_W(X_W), .Y_W(Y_W), .TPR_W(TPR_W)) i_locate (
      .width    (in_width),
      .x        (in_x),
      .y        (in_y),
      .tpr_full (tpr_full),
      .tpr      (c_tpr),
      .tile_row (c_row),
      .col_pos  (c_pos),
      .slot     (c_slot),
      .intra    (c_intra)
   );

   // Stage 1 registers
   logic                  s1_valid;
   logic [TPR_W-1:0]      s1_tpr, s1_pos;
   logic [ROW_W-1:0]      s1_row;
   logic [1:0]            s1_slot;
   logic [INTRA_BITS-1:0] s1_intra;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s1_tpr   <= '0;
         s1_pos   <= '0;
         s1_row   <= '0;
         s1_slot  <= '0;
         s1_intra <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_tpr   <= c_tpr;
            s1_pos   <= c_pos;
            s1_row   <= c_row;
            s1_slot  <= c_slot;
            s1_intra <= c_intra;
         end
      end
   end

   // Stage 2: tile index and final offset
   logic [IDX_W-1:0] tile_idx;

   tfb_tile_mac #(.ROW_W(ROW_W), .TPR_W(TPR_W), .USE_MULT(USE_MULT)) i_mac (
      .row (s1_row),
      .tpr (s1_tpr),
      .pos (s1_pos),
      .idx (tile_idx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_ofs   <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            out_ofs <= {tile_idx, s1_slot, s1_intra};
         end
      end
   end

   // Checks
   logic [IDX_W:0] lim_row, lim_tpr;
   assign lim_row = (IDX_W+1)'(s1_row) + (IDX_W+1)'(1);
   assign lim_tpr = (IDX_W+1)'(s1_tpr);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!out_valid && out_ofs == '0));                        // R1
   AST_S1_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> s1_valid);                                         // R2
   AST_S1_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !s1_valid);                                       // R2
   AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      s1_valid |=> out_valid);                                        // R2
   AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
      !s1_valid |=> !out_valid);                                      // R2
   AST_TILE_COUNT: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (tpr_full != '0 && tpr_full <= TPR_MAX));          // R3
   AST_X_INSIDE: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> in_x < in_width);                                  // R8
   AST_LOW_CARRY: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_ofs[INTRA_BITS-1:0] == $past(s1_intra));      // R5
   AST_SLOT_CARRY: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_ofs[TILE_BYTES-1:INTRA_BITS] == $past(s1_slot)); // R6
   AST_TILE_BOUND: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ({1'b0, out_ofs[OFS_W-1:TILE_BYTES]} <
                     $past(lim_row) * $past(lim_tpr)));               // R9
endmodule

// File: tb/test_tfb_addr_gen.sv
`timescale 1ns/1ps
module test_tfb_addr_gen;
   localparam int X_W = 12;
   localparam int Y_W = 12;
   localparam int OFS_W = 26;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             in_valid = 1'b0;
   logic [X_W-1:0]   in_width = '0;
   logic [X_W-1:0]   in_x = '0;
   logic [Y_W-1:0]   in_y = '0;
   logic             out_valid;
   logic [OFS_W-1:0] out_ofs;

   int  errors = 0;
   int  checks = 0;
   int  cyc = 0;
   bit  done = 0;
   bit  pv [4];
   longint pe [4];
   bit  po [4];
   bit  pd [4];

   always #2.5 clk = ~clk;

   tfb_addr_gen i_tfb_addr_gen (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_width(in_width),
      .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ofs(out_ofs)
   );

   function automatic longint ref_ofs(int w, int x, int y);
      int tpr, trow, tcol, pos, slot;
      bit top, right, odd;
      tpr   = (w + 31) / 32;
      trow  = y / 32;
      tcol  = x / 32;
      odd   = (trow % 2) == 1;
      pos   = odd ? (tpr - 1 - tcol) : tcol;
      top   = (y % 32) >= 16;
      right = (x % 32) >= 16;
      case ({odd, right, top})
         3'b000: slot = 0;  // BL
         3'b001: slot = 1;  // TL
         3'b011: slot = 2;  // TR
         3'b010: slot = 3;  // BR
         3'b111: slot = 0;  // TR
         3'b110: slot = 1;  // BR
         3'b100: slot = 2;  // BL
         default: slot = 3; // TL
      endcase
      return longint'(trow * tpr + pos) * 4096 + slot * 1024
           + (((y % 16) / 4) * 4 + (x % 16) / 4) * 64
           + ((y % 4) * 4 + (x % 4)) * 4;
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(bit v, int w, int x, int y, bit dir);
      int k;
      longint a;
      @(negedge clk);
      k = (cyc + 2) % 4;
      chk("R2 out_valid", longint'(out_valid), longint'(pv[k]));
      if (pv[k] && out_valid) begin
         a = longint'(out_ofs);
         chk("R4 pixel field", a % 64, pe[k] % 64);
         chk("R5 block field", (a / 64) % 16, (pe[k] / 64) % 16);
         chk(po[k] ? "R7 odd slot" : "R6 even slot",
             (a / 1024) % 4, (pe[k] / 1024) % 4);
         chk(pd[k] ? "R3 tile index" : (po[k] ? "R8 mirrored tile" : "R9 tile index"),
             a / 4096, pe[k] / 4096);
      end
      in_valid = v;
      in_width = X_W'(w);
      in_x     = X_W'(x);
      in_y     = Y_W'(y);
      pv[cyc % 4] = v;
      pe[cyc % 4] = ref_ofs(w, x, y);
      po[cyc % 4] = ((y / 32) % 2) == 1;
      pd[cyc % 4] = dir;
      cyc++;
   endtask

   initial begin
      int w, x, y;
      void'($urandom(20240611));
      for (int i = 0; i < 4; i++) begin
         pv[i] = 0; pe[i] = 0; po[i] = 0; pd[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset valid", longint'(out_valid), 0);
      chk("R1 reset offset", longint'(out_ofs), 0);
      rst = 1'b0;

      // Directed corners
      step(1, 1, 0, 0, 1);          // single tile, origin
      step(1, 33, 32, 0, 1);        // rounded to two tiles
      step(1, 33, 0, 32, 1);        // odd row, left tile stored last
      step(1, 33, 32, 32, 1);       // odd row, right tile stored first
      step(1, 4064, 4063, 4095, 1); // widest legal image, last pixel
      step(1, 4064, 0, 4095, 1);
      step(1, 70, 16, 16, 0);       // even top-right
      step(1, 70, 15, 15, 0);       // even bottom-left, last pixel
      step(1, 70, 17, 48, 0);       // odd top-right
      step(1, 70, 5, 33, 0);        // odd bottom-left
      step(0, 70, 0, 0, 0);         // gap
      step(1, 95, 94, 63, 1);       // odd row, mirrored last column
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);

      // Random stream
      for (int n = 0; n < 2000; n++) begin
         w = $urandom_range(4064, 1);
         if (w % 32 == 0) w = w - 1;
         x = $urandom_range(w - 1, 0);
         y = $urandom_range(4095, 0);
         step(($urandom_range(3, 0) != 0), w, x, y, 0);
      end
      for (int n = 0; n < 3; n++) step(0, 0, 0, 0, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule